// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a 32-bit in-order core that overlaps five steps of every instruction: fetch, register read and decode, execute, memory access and register write-back. A set of registers between each pair of neighbouring stages holds the stage's operands and control strobes. In steady state one instruction enters per clock and one retires per clock. The core executes word load, word store, branch-if-equal and five register-to-register operations: add, subtract, AND, OR and signed set-less-than.

The core has no interlocks and no forwarding, so software has to schedule around the latencies. A branch redirects fetch only when it leaves the memory stage, so the three instructions after it always run. A value written back becomes visible to a reader only when the reader is four or more instructions later. Instruction and data storage are small internal word arrays. A loader port fills them while reset is held. A debug port reads any register and the program counter.

Top module: `pipe_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0, all 32 registers become 0 and every inter-stage register becomes an all-zero bubble with no write strobe set.
- R2: When no taken branch is leaving the memory stage, the PC grows by 4 at every rising edge. After reset is released, the PC reads 12 after three edges.
- R3: An instruction with opcode 0 writes to register `rd` (bits 15:11) the result of `rs` (bits 25:21) and `rt` (bits 20:16) under its function code (bits 5:0): 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed less-than (result 1 or 0). The result is written in stage 5 only.
- R4: Opcode 0x23 loads the data word at byte address `rs` + sign-extended bits 15:0 into register `rt`.
- R5: Opcode 0x2B stores register `rt` to the data word at byte address `rs` + sign-extended bits 15:0. A later load from that address returns the stored value.
- R6: Opcode 0x04 compares `rs` with `rt`. If they are equal, the PC becomes PC+4 of the branch plus (sign-extended bits 15:0 shifted left by 2) at the end of the branch's memory stage. The three instructions after a branch always commit, and the fourth is skipped when the branch is taken. A branch that is not taken changes nothing.
- R7: There is no bypass. An instruction one to three places after a writer reads the register's old value, including the third, whose read falls in the same cycle as the write. The fourth reads the new value.
- R8: Register 0 always reads as zero, and writes to it are dropped.
- R9: With `loadEn` high at a rising edge, `loadWord` is written to word `loadAddr` of the data array when `loadToData` is 1, and of the instruction array otherwise.
- R10: `dbgRegVal` shows register `dbgRegSel` without delay, and `dbgPc` shows the PC.
- R11: An opcode-0 word whose function code is not one of those in R3 writes nothing. The all-zero word is such a no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Loader write strobe |
| loadToData | input | 1 | Loader target: 1 data array, 0 instruction array |
| loadAddr | input | AW | Loader word index |
| loadWord | input | 32 | Loader data |
| dbgRegSel | input | 5 | Register index for read-back |
| dbgRegVal | output | 32 | Selected register value |
| dbgPc | output | 32 | Current program counter |

## Verification
Two events can meet in one cycle: a write-back to a register and a decode-stage read of that same register. The program places a load followed by three readers of the load's target, so the third reader's read falls in the write cycle. The check passes only if that reader, like the two before it, holds the old zero, and a fourth reader sees the loaded value. A taken branch is also placed with three instructions after it and a fourth that must never write, while an unequal branch must let the code after it run.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  // strobes produced in decode, carried down the pipe
  typedef struct packed {
    aluOp_e aluOp;
    logic   aluSrcImm;
    logic   regDstRd;
    logic   memWrite;
    logic   branch;
    logic   regWrite;
    logic   memToReg;
  } ctrl_t;

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] pcPlus4;
  } ifId_t;

  typedef struct packed {
    ctrl_t       ctrl;
    logic [31:0] busA;
    logic [31:0] busB;
    logic [31:0] imm;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [31:0] pcPlus4;
  } idEx_t;

  typedef struct packed {
    logic        regWrite;
    logic        memToReg;
    logic        memWrite;
    logic        branch;
    logic        zero;
    logic [31:0] aluRes;
    logic [31:0] target;
    logic [31:0] storeData;
    logic [4:0]  wreg;
  } exMem_t;

  typedef struct packed {
    logic        regWrite;
    logic        memToReg;
    logic [31:0] aluRes;
    logic [31:0] loadData;
    logic [4:0]  wreg;
  } memWb_t;

endpackage

// File: rtl/pipe_control.sv
module pipe_control
  import core_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDstRd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.aluOp = ALU_ADD; ctrl.regWrite = 1'b1; end
          FN_SUB: begin ctrl.aluOp = ALU_SUB; ctrl.regWrite = 1'b1; end
          FN_AND: begin ctrl.aluOp = ALU_AND; ctrl.regWrite = 1'b1; end
          FN_OR:  begin ctrl.aluOp = ALU_OR;  ctrl.regWrite = 1'b1; end
          FN_SLT: begin ctrl.aluOp = ALU_SLT; ctrl.regWrite = 1'b1; end
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_LW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.regWrite  = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_SW: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.aluOp  = ALU_SUB;
        ctrl.branch = 1'b1;
      end
      default: ctrl = ctrl;
    endcase
  end

  AST_STORE_NO_REGWRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite); // R5

  AST_BRANCH_NO_WRITES: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |-> (!ctrl.regWrite && !ctrl.memWrite)); // R6

  AST_UNKNOWN_FUNCT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_RTYPE && funct == 6'h00) |-> !ctrl.regWrite); // R11

endmodule

// File: rtl/pipe_datapath.sv
module pipe_datapath
  import core_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
)(
  input  logic          clk,
  input  logic          rst,
  input  ctrl_t         idCtrl,
  output logic [5:0]    idOpcode,
  output logic [5:0]    idFunct,
  input  logic          loadEn,
  input  logic          loadToData,
  input  logic [AW-1:0] loadAddr,
  input  logic [31:0]   loadWord,
  input  logic [4:0]    dbgRegSel,
  output logic [31:0]   dbgRegVal,
  output logic [31:0]   dbgPc
);

  logic [31:0] imem [MEM_WORDS];
  logic [31:0] dmem [MEM_WORDS];
  logic [31:0] rf   [32];

  logic [31:0] pc;
  ifId_t  ifId;
  idEx_t  idEx;
  exMem_t exMem;
  memWb_t memWb;

  // ---------------- fetch ----------------
  logic [31:0] fetchInstr;
  logic [31:0] pcPlus4;
  logic        takeBranch;

  assign fetchInstr = imem[pc[AW+1:2]];
  assign pcPlus4    = pc + 32'd4;
  assign takeBranch = exMem.branch && exMem.zero;

  always_ff @(posedge clk) begin
    if (loadEn && !loadToData) imem[loadAddr] <= loadWord;
  end

  always_ff @(posedge clk) begin
    if (rst)             pc <= '0;
    else if (takeBranch) pc <= exMem.target;
    else                 pc <= pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) ifId <= '0;
    else     ifId <= '{instr: fetchInstr, pcPlus4: pcPlus4};
  end

  // ---------------- decode ----------------
  logic [4:0]  idRs, idRt, idRd;
  logic [31:0] idImm;

  assign idOpcode = ifId.instr[31:26];
  assign idFunct  = ifId.instr[5:0];
  assign idRs     = ifId.instr[25:21];
  assign idRt     = ifId.instr[20:16];
  assign idRd     = ifId.instr[15:11];
  assign idImm    = {{16{ifId.instr[15]}}, ifId.instr[15:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idEx <= '0;
    end else begin
      idEx.ctrl    <= idCtrl;
      idEx.busA    <= rf[idRs];
      idEx.busB    <= rf[idRt];
      idEx.imm     <= idImm;
      idEx.rt      <= idRt;
      idEx.rd      <= idRd;
      idEx.pcPlus4 <= ifId.pcPlus4;
    end
  end

  // ---------------- execute ----------------
  logic [31:0] aluB, aluRes;
  logic [4:0]  exWreg;

  assign aluB   = idEx.ctrl.aluSrcImm ? idEx.imm : idEx.busB;
  assign exWreg = idEx.ctrl.regDstRd ? idEx.rd : idEx.rt;

  always_comb begin
    case (idEx.ctrl.aluOp)
      ALU_SUB: aluRes = idEx.busA - aluB;
      ALU_AND: aluRes = idEx.busA & aluB;
      ALU_OR:  aluRes = idEx.busA | aluB;
      ALU_SLT: aluRes = {31'd0, ($signed(idEx.busA) < $signed(aluB))};
      default: aluRes = idEx.busA + aluB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exMem <= '0;
    end else begin
      exMem.regWrite  <= idEx.ctrl.regWrite;
      exMem.memToReg  <= idEx.ctrl.memToReg;
      exMem.memWrite  <= idEx.ctrl.memWrite;
      exMem.branch    <= idEx.ctrl.branch;
      exMem.zero      <= (aluRes == 32'd0);
      exMem.aluRes    <= aluRes;
      exMem.target    <= idEx.pcPlus4 + {idEx.imm[29:0], 2'b00};
      exMem.storeData <= idEx.busB;
      exMem.wreg      <= exWreg;
    end
  end

  // ---------------- memory ----------------
  logic [AW-1:0] memIdx;
  assign memIdx = exMem.aluRes[AW+1:2];

  always_ff @(posedge clk) begin
    if (loadEn && loadToData)  dmem[loadAddr] <= loadWord;
    else if (!rst && exMem.memWrite) dmem[memIdx] <= exMem.storeData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memWb <= '0;
    end else begin
      memWb.regWrite <= exMem.regWrite;
      memWb.memToReg <= exMem.memToReg;
      memWb.aluRes   <= exMem.aluRes;
      memWb.loadData <= dmem[memIdx];
      memWb.wreg     <= exMem.wreg;
    end
  end

  // ---------------- write-back ----------------
  logic [31:0] wbData;
  assign wbData = memWb.memToReg ? memWb.loadData : memWb.aluRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (memWb.regWrite && memWb.wreg != 5'd0) begin
      rf[memWb.wreg] <= wbData;
    end
  end

  assign dbgRegVal = rf[dbgRegSel];
  assign dbgPc     = pc;

  // ---------------- assertions ----------------
  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0); // R8

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !takeBranch |=> pc == $past(pc) + 32'd4); // R2

  AST_BRANCH_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    takeBranch |=> pc == $past(exMem.target)); // R6

  AST_WRITE_IN_STAGE5: assert property (@(posedge clk) disable iff (rst)
    exMem.regWrite |=> memWb.regWrite); // R3

endmodule

// File: rtl/pipe_core.sv
module pipe_core
  import core_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          loadEn,
  input  logic          loadToData,
  input  logic [AW-1:0] loadAddr,
  input  logic [31:0]   loadWord,
  input  logic [4:0]    dbgRegSel,
  output logic [31:0]   dbgRegVal,
  output logic [31:0]   dbgPc
);

  ctrl_t      idCtrl;
  logic [5:0] idOpcode;
  logic [5:0] idFunct;

  pipe_control u_control (
    .clk    (clk),
    .rst    (rst),
    .opcode (idOpcode),
    .funct  (idFunct),
    .ctrl   (idCtrl)
  );

  pipe_datapath #(.MEM_WORDS(MEM_WORDS)) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .idCtrl     (idCtrl),
    .idOpcode   (idOpcode),
    .idFunct    (idFunct),
    .loadEn     (loadEn),
    .loadToData (loadToData),
    .loadAddr   (loadAddr),
    .loadWord   (loadWord),
    .dbgRegSel  (dbgRegSel),
    .dbgRegVal  (dbgRegVal),
    .dbgPc      (dbgPc)
  );

endmodule

// File: tb/pipe_core_tb.sv
module pipe_core_tb;

  localparam int MEM_WORDS = 64;
  localparam int AW = $clog2(MEM_WORDS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          loadEn = 1'b0;
  logic          loadToData = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [31:0]   loadWord = '0;
  logic [4:0]    dbgRegSel = '0;
  logic [31:0]   dbgRegVal;
  logic [31:0]   dbgPc;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pipe_core #(.MEM_WORDS(MEM_WORDS)) u_dut (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadToData(loadToData),
    .loadAddr(loadAddr), .loadWord(loadWord), .dbgRegSel(dbgRegSel),
    .dbgRegVal(dbgRegVal), .dbgPc(dbgPc)
  );

  function automatic logic [31:0] encR(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic putWord(input bit toData, input int idx, input logic [31:0] w);
    @(negedge clk);
    loadEn = 1'b1; loadToData = toData; loadAddr = AW'(idx); loadWord = w;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic checkReg(input string req, input int r, input logic [31:0] exp);
    dbgRegSel = 5'(r);
    #1;
    check(req, $sformatf("r%0d", r), dbgRegVal, exp);
  endtask

  // R9: program and data through the loader while reset is held
  task automatic loadProgram();
    for (int i = 0; i < MEM_WORDS; i++) putWord(1'b0, i, 32'd0);
    putWord(1'b1, 0, 32'd100);
    putWord(1'b1, 1, 32'd7);
    putWord(1'b0,  0, encI(6'h23, 0, 1, 16'd0));      // lw r1,0(r0)
    putWord(1'b0,  1, encR(1, 1, 2, 6'h20));          // add r2 (stale)
    putWord(1'b0,  2, encR(1, 1, 3, 6'h20));          // add r3 (stale)
    putWord(1'b0,  3, encR(1, 1, 4, 6'h20));          // add r4 (same-cycle write)
    putWord(1'b0,  4, encR(1, 1, 5, 6'h20));          // add r5 (fresh)
    putWord(1'b0,  5, encI(6'h23, 0, 6, 16'd4));      // lw r6,4(r0)
    putWord(1'b0,  6, encR(5, 5, 21, 6'h01));         // unknown funct
    putWord(1'b0,  9, encR(5, 6, 7, 6'h22));          // sub
    putWord(1'b0, 10, encR(5, 6, 8, 6'h24));          // and
    putWord(1'b0, 11, encR(5, 6, 9, 6'h25));          // or
    putWord(1'b0, 12, encR(6, 5, 10, 6'h2A));         // slt 7<200
    putWord(1'b0, 13, encR(5, 6, 11, 6'h2A));         // slt 200<7
    putWord(1'b0, 14, encI(6'h2B, 0, 7, 16'd8));      // sw r7,8(r0)
    putWord(1'b0, 15, encI(6'h04, 0, 0, 16'd4));      // beq taken -> 80
    putWord(1'b0, 16, encR(5, 5, 12, 6'h20));         // slot 1
    putWord(1'b0, 17, encR(6, 0, 13, 6'h25));         // slot 2
    putWord(1'b0, 18, encR(0, 6, 14, 6'h22));         // slot 3
    putWord(1'b0, 19, encR(5, 5, 15, 6'h20));         // must be skipped
    putWord(1'b0, 20, encI(6'h23, 0, 16, 16'd8));     // lw r16,8(r0)
    putWord(1'b0, 21, encI(6'h04, 1, 0, 16'd4));      // beq not taken
    putWord(1'b0, 22, encR(6, 6, 17, 6'h20));
    putWord(1'b0, 23, encR(5, 5, 0, 6'h20));          // write r0
    putWord(1'b0, 25, encR(16, 0, 19, 6'h20));        // skipped only if wrongly taken
    putWord(1'b0, 26, encI(6'h2B, 0, 17, 16'd12));    // sw r17,12(r0)
    putWord(1'b0, 27, encI(6'h23, 0, 20, 16'd12));    // lw r20,12(r0)
    putWord(1'b0, 28, encI(6'h04, 0, 0, 16'hFFFF));   // spin
  endtask

  task automatic testReset();
    check("R1", "pc in reset", dbgPc, 32'd0);
    checkReg("R1", 1, 32'd0);
    checkReg("R10", 31, 32'd0);
  endtask

  task automatic testSequentialPc();
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", "pc after 3 edges", dbgPc, 32'd12);
  endtask

  task automatic testLoadHazard();
    checkReg("R4", 1, 32'd100);
    checkReg("R7", 2, 32'd0);
    checkReg("R7", 3, 32'd0);
    checkReg("R7", 4, 32'd0);   // read in the write cycle
    checkReg("R7", 5, 32'd200);
    checkReg("R4", 6, 32'd7);
  endtask

  task automatic testAlu();
    checkReg("R3", 7,  32'd193);
    checkReg("R3", 8,  32'd0);
    checkReg("R3", 9,  32'd207);
    checkReg("R3", 10, 32'd1);
    checkReg("R3", 11, 32'd0);
    checkReg("R11", 21, 32'd0);
  endtask

  task automatic testBranch();
    checkReg("R6", 12, 32'd400);
    checkReg("R6", 13, 32'd7);
    checkReg("R6", 14, 32'hFFFF_FFF9);
    checkReg("R6", 15, 32'd0);
    checkReg("R6", 19, 32'd193);
    check("R6", "pc in spin loop", 32'(dbgPc >= 32'd112 && dbgPc <= 32'd124), 32'd1);
  endtask

  task automatic testStoreAndZero();
    checkReg("R5", 16, 32'd193);
    checkReg("R5", 20, 32'd14);
    checkReg("R3", 17, 32'd14);
    checkReg("R8", 0, 32'd0);
  endtask

  initial begin
    loadProgram();
    @(negedge clk);
    testReset();
    testSequentialPc();
    repeat (80) @(negedge clk);
    testLoadHazard();
    testAlu();
    testBranch();
    testStoreAndZero();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule